// File: doc/BRIEF.md
# Interrupt-Capable GPIO Bank

This block is a 32-pin general-purpose I/O bank controlled through a small word-addressed register interface. Software changes pin direction and output levels through registers that only set or only clear bits. A single write therefore changes the chosen pins without a read-modify-write. Pin inputs are resynchronized to the bank clock before they can be read back.

The eight lowest pins can also raise interrupts. For each of these pins, a control word selects edge or level sensing and which polarity or edge counts. The control word is reached only through a set alias and a clear alias. In edge mode, events are held in a sticky status bit until software writes a one to clear it. In level mode, the status bit follows the qualified pin level. All status bits are ORed onto one interrupt line.

Top module: `gpio_irq_bank`

## Requirements
- R1: Only word-aligned accesses (address bits 1:0 zero) act. The byte offsets are 0x00 direction, 0x04 make-output, 0x08 make-input, 0x0C pin value, 0x10 output set, 0x14 output clear, 0x18 control set, 0x1C control clear, 0x20 interrupt clear and 0x24 status. Writes to 0x00, 0x0C and 0x24 are ignored. Offsets 0x04 and 0x08 read the direction word, 0x10 and 0x14 read the output latch, 0x18 and 0x1C read the control word, and 0x20 reads zero.
- R2: A one written to make-output turns that pin into an output (`pinOutEn` bit 1). A one written to make-input turns it back into an input. Zero bits leave the direction unchanged.
- R3: A one written to output set drives that pin's latch high, and a one written to output clear drives it low. Zero bits leave the latch unchanged, and reading either register returns the latch.
- R4: Pin inputs pass through two flops. A change on `pinIn` first appears at offset 0x0C after the second rising clock edge.
- R5: The control word holds rise enables in bits 7:0, fall enables in 15:8, stored-only filter bits in 23:16 and level selects in 31:24. A set-alias write ORs ones into it, and a clear-alias write removes them.
- R6: With its level select at 0, a pin latches status on a synchronized rising edge if its rise bit is set, and on a falling edge if its fall bit is set. With both bits set it latches on either edge. The bit then holds until it is cleared.
- R7: With its level select at 1, a pin's status is 1 while the pin is high and its rise bit is set, or while the pin is low and its fall bit is set. A clear write cannot remove it while that level is present.
- R8: Pins 8 to 31 never produce status, and status bits 31:8 always read 0.
- R9: A pin with both its rise and fall bits cleared records no new status. A status bit latched before masking remains until it is cleared.
- R10: A one written to interrupt clear removes that pin's latched edge status.
- R11: `irqOut` is high exactly when any status bit 7:0 is set.
- R12: After reset every register is 0: all pins are inputs, the output latch is low, interrupts are disabled and no status is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 6 | Byte address of the access |
| busWrEn | input | 1 | Write strobe for one cycle |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for `busAddr`, combinational |
| pinIn | input | 32 | Raw pin levels |
| pinOut | output | 32 | Output latch |
| pinOutEn | output | 32 | Output enable per pin, 1 = output |
| irqOut | output | 1 | Combined interrupt |

## Verification
The hardest case to reach is a level-mode pin whose clear write arrives while the level is still active. Together with it comes a latched edge bit that must survive a mask write. Both depend on the pin's synchronizer delay lining up with the bus writes. The stimulus moves a pin only after the bench has waited out the two-flop delay. It then issues the clear or mask write, and checks status before and after the pin returns to its idle level. A reference model steps alongside the design on every clock, so intermediate cycles are compared as well.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  typedef enum logic [2:0] {
    SEL_DIR,
    SEL_PIN,
    SEL_OUT,
    SEL_CTL,
    SEL_STAT,
    SEL_NONE
  } readSel_t;

  typedef struct packed {
    logic dirOut;
    logic dirIn;
    logic outSet;
    logic outClr;
    logic ctlSet;
    logic ctlClr;
    logic intClr;
  } bankStrobe_t;

endpackage

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output bankStrobe_t       strobe,
  output readSel_t          rdSel
);

  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] wordIdx;
  logic              aligned;
  logic              wrHit;

  assign wordIdx = busAddr[ADDR_W-1:2];
  assign aligned = (busAddr[1:0] == 2'b00);
  assign wrHit   = busWrEn && aligned;

  always_comb begin
    strobe        = '0;
    strobe.dirOut = wrHit && (wordIdx == WORD_W'(1));
    strobe.dirIn  = wrHit && (wordIdx == WORD_W'(2));
    strobe.outSet = wrHit && (wordIdx == WORD_W'(4));
    strobe.outClr = wrHit && (wordIdx == WORD_W'(5));
    strobe.ctlSet = wrHit && (wordIdx == WORD_W'(6));
    strobe.ctlClr = wrHit && (wordIdx == WORD_W'(7));
    strobe.intClr = wrHit && (wordIdx == WORD_W'(8));
  end

  always_comb begin
    rdSel = SEL_NONE;
    if (aligned) begin
      if (wordIdx <= WORD_W'(2))       rdSel = SEL_DIR;
      else if (wordIdx == WORD_W'(3))  rdSel = SEL_PIN;
      else if (wordIdx <= WORD_W'(5))  rdSel = SEL_OUT;
      else if (wordIdx <= WORD_W'(7))  rdSel = SEL_CTL;
      else if (wordIdx == WORD_W'(9))  rdSel = SEL_STAT;
    end
  end

endmodule

// File: rtl/gpio_bank_datapath.sv
module gpio_bank_datapath
  import gpio_bank_pkg::*;
#(
  parameter int PIN_W    = 32,
  parameter int IRQ_PINS = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  bankStrobe_t      strobe,
  input  readSel_t         rdSel,
  input  logic [PIN_W-1:0] wrData,
  input  logic [PIN_W-1:0] pinIn,
  output logic [PIN_W-1:0] pinOut,
  output logic [PIN_W-1:0] pinOutEn,
  output logic [PIN_W-1:0] rdData,
  output logic             irqOut
);

  localparam int CTL_W   = 4 * IRQ_PINS;
  localparam int RISE_LO = 0;
  localparam int FALL_LO = IRQ_PINS;
  localparam int LVL_LO  = 3 * IRQ_PINS;

  logic [PIN_W-1:0]    dirQ;
  logic [PIN_W-1:0]    outQ;
  logic [PIN_W-1:0]    sync1Q;
  logic [PIN_W-1:0]    sync2Q;
  logic [IRQ_PINS-1:0] prevQ;
  logic [CTL_W-1:0]    ctlQ;
  logic [IRQ_PINS-1:0] statQ;
  logic [IRQ_PINS-1:0] statNext;
  logic [PIN_W-1:0]    ctlWide;
  logic [PIN_W-1:0]    statWide;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirQ <= '0;
    end else if (strobe.dirOut) begin
      dirQ <= dirQ | wrData;
    end else if (strobe.dirIn) begin
      dirQ <= dirQ & ~wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outQ <= '0;
    end else if (strobe.outSet) begin
      outQ <= outQ | wrData;
    end else if (strobe.outClr) begin
      outQ <= outQ & ~wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlQ <= '0;
    end else if (strobe.ctlSet) begin
      ctlQ <= ctlQ | wrData[CTL_W-1:0];
    end else if (strobe.ctlClr) begin
      ctlQ <= ctlQ & ~wrData[CTL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sync1Q <= '0;
      sync2Q <= '0;
      prevQ  <= '0;
    end else begin
      sync1Q <= pinIn;
      sync2Q <= sync1Q;
      prevQ  <= sync2Q[IRQ_PINS-1:0];
    end
  end

  always_comb begin
    for (int i = 0; i < IRQ_PINS; i++) begin
      logic riseEn, fallEn, lvlSel, edgeHit, lvlHit, clrHit;
      riseEn   = ctlQ[RISE_LO+i];
      fallEn   = ctlQ[FALL_LO+i];
      lvlSel   = ctlQ[LVL_LO+i];
      edgeHit  = (riseEn && sync2Q[i] && !prevQ[i]) ||
                 (fallEn && !sync2Q[i] && prevQ[i]);
      lvlHit   = (riseEn && sync2Q[i]) || (fallEn && !sync2Q[i]);
      clrHit   = strobe.intClr && wrData[i];
      statNext[i] = lvlSel ? lvlHit : (edgeHit || (statQ[i] && !clrHit));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statQ <= '0;
    else       statQ <= statNext;
  end

  always_comb begin
    ctlWide               = '0;
    ctlWide[CTL_W-1:0]    = ctlQ;
    statWide              = '0;
    statWide[IRQ_PINS-1:0] = statQ;
  end

  always_comb begin
    case (rdSel)
      SEL_DIR:  rdData = dirQ;
      SEL_PIN:  rdData = sync2Q;
      SEL_OUT:  rdData = outQ;
      SEL_CTL:  rdData = ctlWide;
      SEL_STAT: rdData = statWide;
      default:  rdData = '0;
    endcase
  end

  assign pinOut   = outQ;
  assign pinOutEn = dirQ;
  assign irqOut   = |statQ;

  assert_make_output_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.dirOut |=> ((dirQ & $past(wrData)) == $past(wrData)));

  assert_out_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.outSet |=> ((outQ & $past(wrData)) == $past(wrData)));

  assert_upper_status_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rdSel == SEL_STAT) |-> (rdData[PIN_W-1:IRQ_PINS] == '0));

  for (genvar g = 0; g < IRQ_PINS; g++) begin : g_pinChk
    assert_edge_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
      (!ctlQ[LVL_LO+g] && statQ[g] && !(strobe.intClr && wrData[g])) |=> statQ[g]);

    assert_level_high_R7: assert property (@(posedge clk) disable iff (!rstN)
      (ctlQ[LVL_LO+g] && ctlQ[RISE_LO+g] && sync2Q[g]) |=> statQ[g]);

    assert_masked_R9: assert property (@(posedge clk) disable iff (!rstN)
      (!ctlQ[RISE_LO+g] && !ctlQ[FALL_LO+g] && !statQ[g]) |=> !statQ[g]);
  end

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int PIN_W    = 32,
  parameter int IRQ_PINS = 8,
  parameter int ADDR_W   = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [PIN_W-1:0]  busWrData,
  output logic [PIN_W-1:0]  busRdData,
  input  logic [PIN_W-1:0]  pinIn,
  output logic [PIN_W-1:0]  pinOut,
  output logic [PIN_W-1:0]  pinOutEn,
  output logic              irqOut
);

  bankStrobe_t strobe;
  readSel_t    rdSel;

  gpio_bank_ctrl #(
    .ADDR_W(ADDR_W)
  ) i_ctrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .strobe  (strobe),
    .rdSel   (rdSel)
  );

  gpio_bank_datapath #(
    .PIN_W   (PIN_W),
    .IRQ_PINS(IRQ_PINS)
  ) i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .rdSel   (rdSel),
    .wrData  (busWrData),
    .pinIn   (pinIn),
    .pinOut  (pinOut),
    .pinOutEn(pinOutEn),
    .rdData  (busRdData),
    .irqOut  (irqOut)
  );

endmodule

// File: tb/test_gpio_irq_bank.sv
`timescale 1ns/1ps
module test_gpio_irq_bank;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [31:0] pinIn = '0;
  logic [31:0] pinOut;
  logic [31:0] pinOutEn;
  logic        irqOut;

  int nChecks = 0;
  int nFail = 0;

  always #5 clk = ~clk;

  gpio_irq_bank i_gpio_irq_bank (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .pinIn(pinIn),
    .pinOut(pinOut), .pinOutEn(pinOutEn), .irqOut(irqOut)
  );

  // reference model state
  logic [31:0] mDir, mOut, mCtl, m1, m2;
  logic [7:0]  mPrev, mStat;

  function automatic logic [31:0] mRead(logic [5:0] a);
    case (a)
      6'h00, 6'h04, 6'h08: return mDir;
      6'h0C:               return m2;
      6'h10, 6'h14:        return mOut;
      6'h18, 6'h1C:        return mCtl;
      6'h24:               return {24'h0, mStat};
      default:             return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mDir = 0; mOut = 0; mCtl = 0; m1 = 0; m2 = 0; mPrev = 0; mStat = 0;
    end else begin
      logic [7:0]  nStat;
      logic [31:0] nCtl;
      for (int i = 0; i < 8; i++) begin
        bit r, f, lv, hit;
        r  = mCtl[i]; f = mCtl[8+i]; lv = mCtl[24+i];
        if (lv) nStat[i] = (r && m2[i]) || (f && !m2[i]);
        else begin
          hit = (r && m2[i] && !mPrev[i]) || (f && !m2[i] && mPrev[i]);
          nStat[i] = hit || (mStat[i] &&
                     !(busWrEn && busAddr == 6'h20 && busWrData[i]));
        end
      end
      nCtl = mCtl;
      if (busWrEn) begin
        case (busAddr)
          6'h04: mDir = mDir | busWrData;
          6'h08: mDir = mDir & ~busWrData;
          6'h10: mOut = mOut | busWrData;
          6'h14: mOut = mOut & ~busWrData;
          6'h18: nCtl = mCtl | busWrData;
          6'h1C: nCtl = mCtl & ~busWrData;
          default: ;
        endcase
      end
      mPrev = m2[7:0];
      m2    = m1;
      m1    = pinIn;
      mCtl  = nCtl;
      mStat = nStat;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      check("R2 pinOutEn vs model", pinOutEn, mDir);
      check("R3 pinOut vs model", pinOut, mOut);
      check("R11 irqOut vs model", {31'h0, irqOut}, {31'h0, |mStat});
      check("R1 readback vs model", busRdData, mRead(busAddr));
    end
  end

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk); #1;
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk); #1;
    busWrEn = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, logic [31:0] exp, string tag);
    @(negedge clk); #1;
    busAddr = a;
    #1;
    check(tag, busRdData, exp);
  endtask

  task automatic setPins(logic [31:0] v);
    @(negedge clk); #1;
    pinIn = v;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    nChecks++; nFail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rstN = 1'b1;
    // R12 reset state
    rd(6'h00, 32'h0, "R12 direction after reset");
    rd(6'h10, 32'h0, "R12 output latch after reset");
    rd(6'h24, 32'h0, "R12 status after reset");
    check("R12 irqOut after reset", {31'h0, irqOut}, 32'h0);

    // R2 direction
    wr(6'h04, 32'hF0);
    wr(6'h08, 32'h30);
    wr(6'h08, 32'h0);
    rd(6'h00, 32'hC0, "R2 direction after make-output/make-input");
    check("R2 pinOutEn", pinOutEn, 32'hC0);
    rd(6'h04, 32'hC0, "R1 make-output alias reads direction");

    // R3 output set/clear
    wr(6'h10, 32'hFF);
    wr(6'h14, 32'h0F);
    rd(6'h10, 32'hF0, "R3 output set reads latch");
    rd(6'h14, 32'hF0, "R3 output clear reads latch");

    // R1 read-only and misaligned writes ignored
    wr(6'h00, 32'hFFFF);
    wr(6'h05, 32'hFFFF);
    rd(6'h00, 32'hC0, "R1 write to readback/misaligned ignored");
    rd(6'h20, 32'h0, "R1 interrupt clear reads zero");

    // R4 synchronizer delay
    setPins(32'hA5A5_0000);
    rd(6'h0C, 32'hA5A5_0000, "R4 pin value");
    @(negedge clk); #1 pinIn = 32'h1234_0000;
    @(negedge clk); #2 check("R4 one edge later still old", busRdData, 32'hA5A5_0000);
    @(negedge clk); #2 check("R4 two edges later new", busRdData, 32'h1234_0000);
    setPins(32'h0);

    // R6 rising edge pin0
    wr(6'h18, 32'h1);
    setPins(32'h1);
    rd(6'h24, 32'h1, "R6 rising edge latched");
    check("R11 irqOut with pending status", {31'h0, irqOut}, 32'h1);
    setPins(32'h0);
    rd(6'h24, 32'h1, "R6 status sticky after pin falls");
    wr(6'h20, 32'h1);
    rd(6'h24, 32'h0, "R10 clear removes edge status");
    check("R11 irqOut idle", {31'h0, irqOut}, 32'h0);

    // R6 falling edge pin1
    wr(6'h18, 32'h1 << 9);
    setPins(32'h2);
    rd(6'h24, 32'h0, "R6 rise on fall-only pin ignored");
    setPins(32'h0);
    rd(6'h24, 32'h2, "R6 falling edge latched");
    wr(6'h20, 32'h2);

    // R6 both edges pin2
    wr(6'h18, (32'h1 << 2) | (32'h1 << 10));
    setPins(32'h4);
    rd(6'h24, 32'h4, "R6 both-edge rise");
    wr(6'h20, 32'h4);
    setPins(32'h0);
    rd(6'h24, 32'h4, "R6 both-edge fall");
    wr(6'h20, 32'h4);
    rd(6'h24, 32'h0, "R10 clear both-edge pin");

    // R8 high pins
    setPins(32'hFFFF_FF00);
    setPins(32'h0);
    rd(6'h24, 32'h0, "R8 pins above 7 make no status");

    // R7 level high pin3
    wr(6'h18, (32'h1 << 3) | (32'h1 << 27));
    rd(6'h24, 32'h0, "R7 level high idle");
    setPins(32'h8);
    rd(6'h24, 32'h8, "R7 level high active");
    wr(6'h20, 32'h8);
    rd(6'h24, 32'h8, "R7 clear ignored while level active");
    setPins(32'h0);
    rd(6'h24, 32'h0, "R7 status drops with level");

    // R7 level low pin4
    wr(6'h18, (32'h1 << 12) | (32'h1 << 28));
    repeat (2) @(negedge clk);
    rd(6'h24, 32'h10, "R7 level low active");
    setPins(32'h10);
    rd(6'h24, 32'h0, "R7 level low released");

    // R5 control word layout and aliases
    rd(6'h18, 32'h1800_160D, "R5 control word via set alias");
    wr(6'h18, 32'h00FF_0000);
    rd(6'h1C, 32'h18FF_160D, "R5 filter bits stored");
    wr(6'h1C, 32'h00FF_0000);
    rd(6'h18, 32'h1800_160D, "R5 clear alias removes bits");

    // R9 mask pin0 (pin4 held high to keep level-low idle)
    setPins(32'h11);
    rd(6'h24, 32'h1, "R9 pin0 edge latched before mask");
    wr(6'h1C, 32'h1);
    rd(6'h24, 32'h1, "R9 latched bit survives mask");
    wr(6'h20, 32'h1);
    setPins(32'h10);
    setPins(32'h11);
    rd(6'h24, 32'h0, "R9 masked pin records nothing");

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule